// File: doc/BRIEF.md
# Smart Card Contact Power-Down Sequencer

This block takes a contact smart card interface from its live state to a fully powered-down, clamped state in a fixed order. Each step comes at a fixed offset of a time unit `UNIT_CLKS`, counted in system clock cycles. There are two triggers. The host can clear its session-enable level. A current-limit fault can also be reported on the card clock, data, reset or supply contact. When a fault starts the power-down, the block also sets a sticky protection flag and pulls an active-low interrupt low.

The block has seven states. `ST_OFF` is the clamped, powered-down state that reset selects. `ST_LIVE` is the powered state with the contacts enabled; it is entered from `ST_OFF` when the session is enabled and no protection flag is set. The power-down then passes through five hold states. `ST_HOLD_RST` waits UNIT_CLKS/64 cycles before the reset line falls. `ST_HOLD_CLK`, `ST_HOLD_IO` and `ST_HOLD_VCC` each last UNIT_CLKS/2 cycles. `ST_HOLD_PWR` lasts 2·UNIT_CLKS cycles and then returns to `ST_OFF`. Each hold state leaves when a single reloaded down-counter reaches zero. The transitions are:
- OFF→LIVE on activation.
- LIVE→HOLD_RST when the session is cleared or a qualified fault occurs.
- HOLD_RST→HOLD_CLK→HOLD_IO→HOLD_VCC→HOLD_PWR→OFF, each on counter expiry.

The activation ramp is reduced to a one-cycle move into `ST_LIVE`. Analog slew control and current sensing are outside the block.

Top module: `card_teardown_seq`

## Requirements
- R1: After reset, `card_rst`=0 and `card_clk_en`=0. The signals `io_force_low`, `vcc_ramp_dn`, `conv_stop`, `contact_clamp`, `osc_slow` and `seq_done` are all 1. `prot`=0 and `irq_n`=1.
- R2: In the off state, if `sess_en`=1 and `prot`=0 at a clock edge, the block is live after that edge. Live means `card_rst`=1 and `card_clk_en`=1; `io_force_low`, `vcc_ramp_dn`, `conv_stop`, `contact_clamp`, `osc_slow` and `seq_done` are all 0.
- R3: While live, the first edge that samples `sess_en`=0 is edge E0. `card_rst` falls after edge E0+UNIT_CLKS/64 and not earlier.
- R4: `card_clk_en` falls UNIT_CLKS/2 edges after `card_rst` falls.
- R5: `io_force_low` rises UNIT_CLKS edges after `card_rst` falls.
- R6: `vcc_ramp_dn` rises 3·UNIT_CLKS/2 edges after `card_rst` falls.
- R7: 7·UNIT_CLKS/2 edges after `card_rst` falls, `conv_stop`, `contact_clamp`, `osc_slow` and `seq_done` all rise on the same edge.
- R8: While live, a fault on `flt_clk`, `flt_io` or `flt_vcc` starts the same timed power-down from that edge, exactly as in R3–R7. After that edge, `prot`=1 and `irq_n`=0.
- R9: `flt_rst` counts as a fault only while `card_rst` is 0.
- R10: A fault during a power-down that is already running does not change its timing. It only sets `prot` and clears `irq_n`.
- R11: `prot` stays 1, and `irq_n` stays 0, until an edge samples `prot_clr`=1 with no qualified fault. A qualified fault in the same cycle as `prot_clr` keeps `prot` set.
- R12: While `prot`=1, `sess_en`=1 does not leave the off state.
- R13: In the off state, faults on any contact are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sess_en | input | 1 | Host session-enable level |
| prot_clr | input | 1 | Host clear of the protection flag |
| flt_clk | input | 1 | Current-limit fault, clock contact |
| flt_io | input | 1 | Current-limit fault, data contact |
| flt_rst | input | 1 | Current-limit fault, reset contact |
| flt_vcc | input | 1 | Current-limit fault, supply contact |
| card_rst | output | 1 | Card reset level |
| card_clk_en | output | 1 | Card clock gate enable |
| io_force_low | output | 1 | Force the data contact to 0 |
| vcc_ramp_dn | output | 1 | Enable the supply ramp-down |
| conv_stop | output | 1 | Stop the DC-DC converter |
| contact_clamp | output | 1 | Clamp all contacts to card ground |
| osc_slow | output | 1 | Select the low-frequency oscillator |
| irq_n | output | 1 | Active-low interrupt |
| prot | output | 1 | Sticky protection status |
| seq_done | output | 1 | Final clamped state reached |

## Verification
On every cycle, the assertions check three things. First, each contact step happens only after the steps before it. Second, the protection flag stays set and activation stays refused while it is set. Third, faults are qualified correctly: a reset-contact fault while reset is high, or any fault in the off state, never sets the flag. The exact cycle spacing of the five steps can only be shown by the bench's scenarios. The same holds for the unchanged timing when a fault lands mid-sequence and for the set-over-clear priority. The bench compares every output against a timestamp-based model and also checks the boundary cycles one by one.

// File: rtl/cts_pkg.sv
package cts_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_LIVE,
        ST_HOLD_RST,
        ST_HOLD_CLK,
        ST_HOLD_IO,
        ST_HOLD_VCC,
        ST_HOLD_PWR
    } seq_state_e;

    typedef struct packed {
        logic card_rst;
        logic clk_en;
        logic io_low;
        logic vcc_dn;
        logic conv_stop;
        logic clamp;
        logic osc_slow;
    } contact_ctrl_t;

endpackage

// File: rtl/cts_step_timer.sv
module cts_step_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/cts_fault_guard.sv
module cts_fault_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic rst_level,
    input  logic flt_clk,
    input  logic flt_io,
    input  logic flt_rst,
    input  logic flt_vcc,
    input  logic clr,
    output logic fault_hit,
    output logic prot_q
);

    logic rst_fault;

    // reset-contact fault only counts while the reset line is driven low
    assign rst_fault = flt_rst & ~rst_level;
    assign fault_hit = armed & (flt_clk | flt_io | flt_vcc | rst_fault);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prot_q <= 1'b0;
        end else if (fault_hit) begin
            prot_q <= 1'b1;
        end else if (clr) begin
            prot_q <= 1'b0;
        end
    end

endmodule

// File: rtl/cts_fsm.sv
module cts_fsm
    import cts_pkg::*;
#(
    parameter int UNIT_CLKS = 128,
    parameter int CW        = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sess_en,
    input  logic          prot,
    input  logic          fault_hit,
    input  logic          tmr_expired,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output contact_ctrl_t ctrl,
    output logic          seq_done
);

    localparam int DUR_RST  = UNIT_CLKS / 64;
    localparam int DUR_HALF = UNIT_CLKS / 2;
    localparam int DUR_PWR  = 2 * UNIT_CLKS;
    localparam logic [CW-1:0] LD_RST  = CW'(DUR_RST - 1);
    localparam logic [CW-1:0] LD_HALF = CW'(DUR_HALF - 1);
    localparam logic [CW-1:0] LD_PWR  = CW'(DUR_PWR - 1);

    seq_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d     = st_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (st_q)
            ST_OFF: begin
                if (sess_en && !prot) begin
                    st_d = ST_LIVE;
                end
            end
            ST_LIVE: begin
                if (!sess_en || fault_hit) begin
                    st_d     = ST_HOLD_RST;
                    tmr_load = 1'b1;
                    tmr_val  = LD_RST;
                end
            end
            ST_HOLD_RST: begin
                if (tmr_expired) begin
                    st_d     = ST_HOLD_CLK;
                    tmr_load = 1'b1;
                    tmr_val  = LD_HALF;
                end
            end
            ST_HOLD_CLK: begin
                if (tmr_expired) begin
                    st_d     = ST_HOLD_IO;
                    tmr_load = 1'b1;
                    tmr_val  = LD_HALF;
                end
            end
            ST_HOLD_IO: begin
                if (tmr_expired) begin
                    st_d     = ST_HOLD_VCC;
                    tmr_load = 1'b1;
                    tmr_val  = LD_HALF;
                end
            end
            ST_HOLD_VCC: begin
                if (tmr_expired) begin
                    st_d     = ST_HOLD_PWR;
                    tmr_load = 1'b1;
                    tmr_val  = LD_PWR;
                end
            end
            ST_HOLD_PWR: begin
                if (tmr_expired) begin
                    st_d = ST_OFF;
                end
            end
            default: st_d = ST_OFF;
        endcase
    end

    always_comb begin
        ctrl     = '{card_rst: 1'b1, clk_en: 1'b1, io_low: 1'b0, vcc_dn: 1'b0,
                     conv_stop: 1'b0, clamp: 1'b0, osc_slow: 1'b0};
        seq_done = 1'b0;
        unique case (st_q)
            ST_OFF: begin
                ctrl     = '{card_rst: 1'b0, clk_en: 1'b0, io_low: 1'b1, vcc_dn: 1'b1,
                             conv_stop: 1'b1, clamp: 1'b1, osc_slow: 1'b1};
                seq_done = 1'b1;
            end
            ST_LIVE, ST_HOLD_RST: begin
            end
            ST_HOLD_CLK: begin
                ctrl.card_rst = 1'b0;
            end
            ST_HOLD_IO: begin
                ctrl.card_rst = 1'b0;
                ctrl.clk_en   = 1'b0;
            end
            ST_HOLD_VCC: begin
                ctrl.card_rst = 1'b0;
                ctrl.clk_en   = 1'b0;
                ctrl.io_low   = 1'b1;
            end
            ST_HOLD_PWR: begin
                ctrl.card_rst = 1'b0;
                ctrl.clk_en   = 1'b0;
                ctrl.io_low   = 1'b1;
                ctrl.vcc_dn   = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/card_teardown_seq.sv
module card_teardown_seq
    import cts_pkg::*;
#(
    parameter int UNIT_CLKS = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sess_en,
    input  logic prot_clr,
    input  logic flt_clk,
    input  logic flt_io,
    input  logic flt_rst,
    input  logic flt_vcc,
    output logic card_rst,
    output logic card_clk_en,
    output logic io_force_low,
    output logic vcc_ramp_dn,
    output logic conv_stop,
    output logic contact_clamp,
    output logic osc_slow,
    output logic irq_n,
    output logic prot,
    output logic seq_done
);

    localparam int CW = $clog2(2 * UNIT_CLKS + 1);

    contact_ctrl_t ctrl;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_expired;
    logic          fault_hit;
    logic          prot_q;

    cts_step_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    cts_fault_guard u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .armed     (~seq_done),
        .rst_level (ctrl.card_rst),
        .flt_clk   (flt_clk),
        .flt_io    (flt_io),
        .flt_rst   (flt_rst),
        .flt_vcc   (flt_vcc),
        .clr       (prot_clr),
        .fault_hit (fault_hit),
        .prot_q    (prot_q)
    );

    cts_fsm #(.UNIT_CLKS(UNIT_CLKS), .CW(CW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sess_en     (sess_en),
        .prot        (prot_q),
        .fault_hit   (fault_hit),
        .tmr_expired (tmr_expired),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .ctrl        (ctrl),
        .seq_done    (seq_done)
    );

    assign card_rst      = ctrl.card_rst;
    assign card_clk_en   = ctrl.clk_en;
    assign io_force_low  = ctrl.io_low;
    assign vcc_ramp_dn   = ctrl.vcc_dn;
    assign conv_stop     = ctrl.conv_stop;
    assign contact_clamp = ctrl.clamp;
    assign osc_slow      = ctrl.osc_slow;
    assign prot          = prot_q;
    assign irq_n         = ~prot_q;

endmodule

// File: rtl/cts_checker.sv
module cts_checker (
    input logic clk,
    input logic rst_n,
    input logic sess_en,
    input logic prot_clr,
    input logic flt_clk,
    input logic flt_io,
    input logic flt_rst,
    input logic flt_vcc,
    input logic card_rst,
    input logic card_clk_en,
    input logic io_force_low,
    input logic vcc_ramp_dn,
    input logic contact_clamp,
    input logic prot,
    input logic seq_done
);

    a_r2_activate: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done && sess_en && !prot |=> !seq_done && card_rst);

    a_r4_clk_after_rst: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(card_clk_en) |-> !card_rst);

    a_r5_io_after_clk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(io_force_low) |-> !card_clk_en && !card_rst);

    a_r6_vcc_after_io: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vcc_ramp_dn) |-> io_force_low && $past(io_force_low));

    a_r7_clamp_last: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(contact_clamp) |-> vcc_ramp_dn && $past(vcc_ramp_dn) && !card_clk_en);

    a_r8_fault_sets_prot: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_done && (flt_clk || flt_io || flt_vcc) |=> prot);

    a_r9_rst_fault_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !prot && card_rst && !flt_clk && !flt_io && !flt_vcc |=> !prot);

    a_r11_prot_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        prot && !prot_clr |=> prot);

    a_r12_refuse: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done && prot |=> seq_done);

    a_r13_off_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done && !prot |=> !prot);

endmodule

bind card_teardown_seq cts_checker u_cts_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .sess_en       (sess_en),
    .prot_clr      (prot_clr),
    .flt_clk       (flt_clk),
    .flt_io        (flt_io),
    .flt_rst       (flt_rst),
    .flt_vcc       (flt_vcc),
    .card_rst      (card_rst),
    .card_clk_en   (card_clk_en),
    .io_force_low  (io_force_low),
    .vcc_ramp_dn   (vcc_ramp_dn),
    .contact_clamp (contact_clamp),
    .prot          (prot),
    .seq_done      (seq_done)
);

// File: tb/card_teardown_seq_bench.sv
module card_teardown_seq_bench;

    localparam int U     = 128;
    localparam int D1    = U / 64;
    localparam int TOTAL = D1 + (7 * U) / 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sess_en = 1'b0, prot_clr = 1'b0;
    logic flt_clk = 1'b0, flt_io = 1'b0, flt_rst = 1'b0, flt_vcc = 1'b0;
    logic card_rst, card_clk_en, io_force_low, vcc_ramp_dn;
    logic conv_stop, contact_clamp, osc_slow, irq_n, prot, seq_done;

    int n_run = 0;
    int n_fail = 0;
    bit ended = 1'b0;

    always #5 clk = ~clk;

    card_teardown_seq #(.UNIT_CLKS(U)) u_card_teardown_seq (
        .clk(clk), .rst_n(rst_n), .sess_en(sess_en), .prot_clr(prot_clr),
        .flt_clk(flt_clk), .flt_io(flt_io), .flt_rst(flt_rst), .flt_vcc(flt_vcc),
        .card_rst(card_rst), .card_clk_en(card_clk_en), .io_force_low(io_force_low),
        .vcc_ramp_dn(vcc_ramp_dn), .conv_stop(conv_stop), .contact_clamp(contact_clamp),
        .osc_slow(osc_slow), .irq_n(irq_n), .prot(prot), .seq_done(seq_done)
    );

    // behavioural reference: mode + edge count since teardown start
    localparam int M_OFF = 0, M_LIVE = 1, M_TEAR = 2;
    int  m_mode = M_OFF;
    int  m_cyc  = 0;
    int  m_t0   = 0;
    bit  m_prot = 1'b0;

    function automatic bit exp_rst();
        if (m_mode == M_LIVE) return 1'b1;
        if (m_mode == M_TEAR) return (m_cyc - m_t0) < D1;
        return 1'b0;
    endfunction
    function automatic bit exp_clk();
        if (m_mode == M_LIVE) return 1'b1;
        if (m_mode == M_TEAR) return (m_cyc - m_t0) < D1 + U / 2;
        return 1'b0;
    endfunction
    function automatic bit exp_io();
        if (m_mode == M_OFF) return 1'b1;
        if (m_mode == M_TEAR) return (m_cyc - m_t0) >= D1 + U;
        return 1'b0;
    endfunction
    function automatic bit exp_vcc();
        if (m_mode == M_OFF) return 1'b1;
        if (m_mode == M_TEAR) return (m_cyc - m_t0) >= D1 + (3 * U) / 2;
        return 1'b0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = M_OFF; m_cyc = 0; m_t0 = 0; m_prot = 1'b0;
        end else begin
            bit flt;
            int n;
            flt = (m_mode != M_OFF) &&
                  (flt_clk || flt_io || flt_vcc || (flt_rst && !exp_rst()));
            n = m_cyc + 1;
            if (flt) m_prot = 1'b1;
            else if (prot_clr) m_prot = 1'b0;
            if (m_mode == M_TEAR) begin
                if (n - m_t0 >= TOTAL) m_mode = M_OFF;
            end else if (m_mode == M_LIVE) begin
                if (!sess_en || flt) begin m_mode = M_TEAR; m_t0 = n; end
            end else if (sess_en && !m_prot_before(flt)) begin
                m_mode = M_LIVE;
            end
            m_cyc = n;
        end
    end

    // activation looks at the flag as it stood before this edge
    bit m_prot_prev = 1'b0;
    function automatic bit m_prot_before(bit unused);
        return m_prot_prev;
    endfunction
    always @(posedge clk) begin
        #3;
        m_prot_prev = m_prot;
    end

    task automatic chk(string tag, logic act, logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        #1;
        if (rst_n && !ended) begin
            bit off;
            off = (m_mode == M_OFF);
            chk("R3 model card_rst", card_rst, exp_rst());
            chk("R4 model card_clk_en", card_clk_en, exp_clk());
            chk("R5 model io_force_low", io_force_low, exp_io());
            chk("R6 model vcc_ramp_dn", vcc_ramp_dn, exp_vcc());
            chk("R7 model conv_stop", conv_stop, off);
            chk("R7 model contact_clamp", contact_clamp, off);
            chk("R7 model osc_slow", osc_slow, off);
            chk("R7 model seq_done", seq_done, off);
            chk("R11 model prot", prot, m_prot);
            chk("R8 model irq_n", irq_n, !m_prot);
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic finish_run();
        ended = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 card_rst", card_rst, 1'b0);
        chk("R1 clk_en", card_clk_en, 1'b0);
        chk("R1 clamp", contact_clamp, 1'b1);
        chk("R1 done", seq_done, 1'b1);
        chk("R1 prot", prot, 1'b0);
        chk("R1 irq_n", irq_n, 1'b1);

        // R2 activation, then R3..R7 exact step edges
        sess_en = 1'b1;
        tick(1);
        chk("R2 live rst", card_rst, 1'b1);
        chk("R2 live done", seq_done, 1'b0);
        chk("R2 live clamp", contact_clamp, 1'b0);
        tick(4);
        sess_en = 1'b0;
        tick(D1);
        chk("R3 rst still high", card_rst, 1'b1);
        tick(1);
        chk("R3 rst fell", card_rst, 1'b0);
        tick(U / 2 - 1);
        chk("R4 clk still on", card_clk_en, 1'b1);
        tick(1);
        chk("R4 clk stopped", card_clk_en, 1'b0);
        tick(U / 2 - 1);
        chk("R5 io not forced", io_force_low, 1'b0);
        tick(1);
        chk("R5 io forced", io_force_low, 1'b1);
        tick(U / 2 - 1);
        chk("R6 vcc not ramping", vcc_ramp_dn, 1'b0);
        tick(1);
        chk("R6 vcc ramping", vcc_ramp_dn, 1'b1);
        tick(2 * U - 1);
        chk("R7 not clamped yet", contact_clamp, 1'b0);
        chk("R7 not done yet", seq_done, 1'b0);
        tick(1);
        chk("R7 clamp", contact_clamp, 1'b1);
        chk("R7 conv_stop", conv_stop, 1'b1);
        chk("R7 osc_slow", osc_slow, 1'b1);
        chk("R7 done", seq_done, 1'b1);
        chk("R7 no prot", prot, 1'b0);

        // R9 reset-contact fault while reset high is ignored
        sess_en = 1'b1;
        tick(2);
        flt_rst = 1'b1;
        tick(1);
        flt_rst = 1'b0;
        chk("R9 rst fault masked prot", prot, 1'b0);
        chk("R9 still live", card_rst, 1'b1);

        // R8 emergency from clock fault while session still enabled
        flt_clk = 1'b1;
        tick(1);
        flt_clk = 1'b0;
        chk("R8 prot set", prot, 1'b1);
        chk("R8 irq_n low", irq_n, 1'b0);
        tick(D1 - 1);
        chk("R8 rst still high", card_rst, 1'b1);
        tick(1);
        chk("R8 rst fell", card_rst, 1'b0);
        // R11 fault beats clear in same cycle
        prot_clr = 1'b1;
        flt_vcc  = 1'b1;
        tick(1);
        prot_clr = 1'b0;
        flt_vcc  = 1'b0;
        chk("R11 set beats clear", prot, 1'b1);
        tick(TOTAL);
        chk("R8 teardown done", seq_done, 1'b1);
        // R12 activation refused with flag set
        tick(5);
        chk("R12 refused done", seq_done, 1'b1);
        chk("R12 refused rst", card_rst, 1'b0);
        chk("R11 sticky irq", irq_n, 1'b0);
        prot_clr = 1'b1;
        tick(1);
        prot_clr = 1'b0;
        chk("R11 cleared", prot, 1'b0);
        chk("R11 irq released", irq_n, 1'b1);
        chk("R12 still off on clear edge", seq_done, 1'b1);
        tick(1);
        chk("R2 reactivated", seq_done, 1'b0);

        // R10 fault mid-sequence keeps timing
        tick(3);
        sess_en = 1'b0;
        tick(D1 + 1);
        chk("R10 rst low", card_rst, 1'b0);
        flt_rst = 1'b1;
        tick(1);
        flt_rst = 1'b0;
        chk("R9 rst fault counts when low", prot, 1'b1);
        tick(U / 2 - 2);
        chk("R10 clk still on", card_clk_en, 1'b1);
        tick(1);
        chk("R10 clk stopped on time", card_clk_en, 1'b0);
        tick(3 * U - 1);
        chk("R10 not done early", seq_done, 1'b0);
        tick(1);
        chk("R10 done on time", seq_done, 1'b1);

        // R13 faults in off state ignored
        prot_clr = 1'b1;
        tick(1);
        prot_clr = 1'b0;
        flt_clk = 1'b1; flt_io = 1'b1; flt_rst = 1'b1; flt_vcc = 1'b1;
        tick(1);
        flt_clk = 1'b0; flt_io = 1'b0; flt_rst = 1'b0; flt_vcc = 1'b0;
        chk("R13 prot stays clear", prot, 1'b0);
        chk("R13 irq stays high", irq_n, 1'b1);
        chk("R13 still off", seq_done, 1'b1);
        tick(2);
        finish_run();
    end

endmodule